// File: doc/BRIEF.md
# Presettable Four-Bit Synchronous Binary Counter

This block is an up counter with a preset input. It steps through sixteen states in plain binary order and goes back to zero after the all-ones state. Four operating modes exist, ranked by priority. An active-low asynchronous clear has the highest priority. Below it come an active-low synchronous preset from a data word, then counting, then holding the current value.

Counting needs two enables to be high. The first is a local enable. The second is a cascade enable, and it also gates the terminal-count flag. The terminal-count flag of one stage can drive the cascade enable of the next stage, so several stages share one clock and form a wider counter.

Top module: `bincnt_preset`

## Requirements
- R1: While counting, the state goes up by one on each rising clock edge, modulo 16. From 15 (4'b1111) the next state is 0.
- R2: Modes rank as follows, highest first: clear, preset, count, hold. A low `rst_n` beats a low `load_n`. A low `load_n` beats any setting of the enables.
- R3: While `rst_n` is low, `cnt_q` is 0. This takes effect at once, without waiting for a clock edge.
- R4: With `rst_n` high and `load_n` low, `cnt_q` takes the value of `din` at the next rising edge, whatever the enables are.
- R5: With `rst_n` and `load_n` high, `cnt_q` increments at a rising edge only when `en_par` and `en_casc` are both high.
- R6: With `rst_n` and `load_n` high, if `en_par` or `en_casc` is low, `cnt_q` keeps its value across the rising edge.
- R7: `carry_out` is combinational. It is 1 exactly when `cnt_q` is 15 and `en_casc` is 1.
- R8: `en_par` and `load_n` have no effect on `carry_out`.
- R9: When `rst_n` is released, `cnt_q` stays 0 until the next rising edge. After that edge it still stays 0 unless a preset or a count takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes except the clear happen on its rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous preset strobe, active low |
| en_par | input | 1 | Local count enable |
| en_casc | input | 1 | Cascade count enable. It also gates `carry_out` |
| din | input | 4 | Preset value |
| cnt_q | output | 4 | Counter state |
| carry_out | output | 1 | Terminal-count flag |

## Verification
The embedded assertions check these behaviours on every clock cycle:
- the preset, increment and hold transitions of the state;
- the wrap from 15 to 0;
- the fall of the terminal-count flag after it causes a wrap;
- a zero state while the clear is held.

Some behaviours only the bench's scenarios can show:
- the immediate, edge-free effect of a clear asserted mid-cycle;
- the quiet release of the clear;
- the indifference of the terminal-count flag to the local enable and the preset strobe.

The bench's scoreboard also runs presets of all sixteen values and wraps under every enable pair. It then runs a random sequence of modes and compares each result with an independent model.

// File: rtl/bincnt_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the presettable binary counter.
// Assumes: consumers import it before declaring mode-typed signals.
package bincnt_pkg;

    // Operating mode that applies at the next rising edge (clear is handled apart).
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2
    } cnt_mode_e;

endpackage

// File: rtl/bincnt_mode_dec.sv
`timescale 1ns/1ps
// Module: bincnt_mode_dec
// Resolves the synchronous mode from the preset strobe and the two enables.
// Preset outranks counting, and counting outranks holding.
// Assumes: the clear is applied directly at the register, so it is not decoded here.
module bincnt_mode_dec
    import bincnt_pkg::*;
(
    input  logic      load_n,
    input  logic      en_par,
    input  logic      en_casc,
    output cnt_mode_e mode
);

    // Purpose: priority decode of the synchronous mode.
    always_comb begin
        if (!load_n) begin
            mode = MODE_LOAD;
        end else if (en_par && en_casc) begin
            mode = MODE_COUNT;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/bincnt_state_reg.sv
`timescale 1ns/1ps
// Module: bincnt_state_reg
// Holds the counter state. It clears asynchronously on a low rst_n.
// On each rising edge it applies the decoded mode: preset, increment or hold.
// Assumes: mode and din are stable around the rising edge of clk.
module bincnt_state_reg
    import bincnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_mode_e        mode,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] ZERO = '0;

    // Purpose: state register with asynchronous clear and a mode-driven next value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= ZERO;
        end else begin
            case (mode)
                MODE_LOAD:  q <= din;
                MODE_COUNT: q <= q + 1'b1;
                default:    q <= q;
            endcase
        end
    end

    // R4: a preset takes the data word seen at the edge.
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |=> (q == $past(din)))
        else $error("p_load_r4 violated");

    // R5: counting adds one, modulo the width.
    p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COUNT) |=> (q == WIDTH'($past(q) + 1'b1)))
        else $error("p_count_r5 violated");

    // R6: hold keeps the state.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(q))
        else $error("p_hold_r6 violated");

    // R3: while the clear is held the state reads zero.
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            p_clear_r3: assert (q == ZERO)
                else $error("p_clear_r3 violated");
        end
    end

endmodule

// File: rtl/bincnt_term_detect.sv
`timescale 1ns/1ps
// Module: bincnt_term_detect
// Raises the terminal-count flag when every state bit is set and the cascade enable is high.
// Assumes: the flag feeds the cascade enable of the next stage, never a clock or a clear.
module bincnt_term_detect #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_casc,
    output logic             tc
);

    logic [WIDTH-1:0] all_ones;

    // Purpose: running AND chain across the state bits.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_chain
            if (i == 0) begin : g_first
                assign all_ones[i] = q[i];
            end else begin : g_rest
                assign all_ones[i] = all_ones[i-1] & q[i];
            end
        end
    endgenerate

    // Purpose: gate the chain result with the cascade enable.
    always_comb begin
        tc = all_ones[WIDTH-1] & en_casc;
    end

endmodule

// File: rtl/bincnt_preset.sv
`timescale 1ns/1ps
// Module: bincnt_preset
// Top of the presettable synchronous up counter.
// Modes by priority: asynchronous clear, synchronous preset, count, hold.
// Assumes: rst_n may change at any time. Every other input meets setup and hold to clk.
module bincnt_preset
    import bincnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             en_par,
    input  logic             en_casc,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cnt_q,
    output logic             carry_out
);

    localparam logic [WIDTH-1:0] TOP_VAL = '1;

    cnt_mode_e mode;

    bincnt_mode_dec u_dec (
        .load_n  (load_n),
        .en_par  (en_par),
        .en_casc (en_casc),
        .mode    (mode)
    );

    bincnt_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .din   (din),
        .q     (cnt_q)
    );

    bincnt_term_detect #(.WIDTH(WIDTH)) u_tc (
        .q       (cnt_q),
        .en_casc (en_casc),
        .tc      (carry_out)
    );

    // R1: counting from the top value wraps to zero.
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_casc && cnt_q == TOP_VAL) |=> (cnt_q == '0))
        else $error("p_wrap_r1 violated");

    // R7: a flag that triggers a count drops after the wrap.
    p_tc_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_out && load_n && en_par) |=> (!carry_out && cnt_q == '0))
        else $error("p_tc_wrap_r7 violated");

    // R2: a preset wins over counting.
    p_prec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && en_par && en_casc) |=> (cnt_q == $past(din)))
        else $error("p_prec_r2 violated");

endmodule

// File: tb/bincnt_preset_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results, and the monitor pops and compares them at the falling edge.
module bincnt_preset_tb;

    typedef struct {
        logic [3:0] q;
        logic       tc;
        string      req;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic       en_par = 1'b0;
    logic       en_casc = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] cnt_q;
    logic       carry_out;

    int         n_cmp = 0;
    int         n_bad = 0;
    logic [3:0] model = 4'd0;
    exp_item_t  sb[$];
    bit         done = 1'b0;

    always #10 clk = ~clk;

    bincnt_preset u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .en_par    (en_par),
        .en_casc   (en_casc),
        .din       (din),
        .cnt_q     (cnt_q),
        .carry_out (carry_out)
    );

    task automatic check(string req, logic [3:0] aq, logic atc, logic [3:0] eq, logic etc);
        n_cmp++;
        if (aq !== eq || atc !== etc) begin
            n_bad++;
            $display("FAIL %s: actual q=%0d tc=%b expected q=%0d tc=%b", req, aq, atc, eq, etc);
        end
    endtask

    // Driver: apply one cycle of inputs, advance the model, push the expected result.
    task automatic step(logic ld, logic ep, logic et, logic [3:0] d, string req);
        exp_item_t it;
        load_n = ld; en_par = ep; en_casc = et; din = d;
        @(posedge clk);
        if (rst_n) begin
            if (!ld) model = d;
            else if (ep && et) model = model + 4'd1;
        end else begin
            model = 4'd0;
        end
        it.q = model; it.tc = (model == 4'hF) && et; it.req = req;
        sb.push_back(it);
        @(negedge clk); #5;
    endtask

    // Monitor: compare each result half a cycle after the edge that made it.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() != 0) begin
                exp_item_t it;
                it = sb.pop_front();
                check(it.req, cnt_q, carry_out, it.q, it.tc);
            end
        end
    end

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); #5;
        check("R3 reset state", cnt_q, carry_out, 4'd0, 1'b0);
        // R9: release mid-cycle, no change before or at the next edge without a count.
        rst_n = 1'b1; #1;
        check("R9 release", cnt_q, carry_out, 4'd0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 4'd9, "R9 idle after release");
        step(1'b1, 1'b0, 1'b1, 4'd9, "R6 hold ep low");
        // R4 presets of every value under varying enables.
        for (int v = 0; v < 16; v++) begin
            step(1'b0, v[0], v[1], 4'(v), "R4 preset");
        end
        // R1 R5: free counting through the wrap.
        step(1'b0, 1'b0, 1'b0, 4'd12, "R4 preset 12");
        for (int k = 0; k < 20; k++) step(1'b1, 1'b1, 1'b1, 4'd0, "R1 R5 count");
        // R1 R6 R7 R8: the wrap point under each enable pair.
        for (int c = 0; c < 4; c++) begin
            step(1'b0, 1'b0, 1'b1, 4'hF, "R8 preset top tc");
            step(1'b1, c[0], c[1], 4'd3, "R1 R6 R7 wrap pair");
        end
        step(1'b0, 1'b0, 1'b1, 4'hF, "R8 tc with load_n low");
        step(1'b1, 1'b0, 1'b1, 4'd0, "R8 tc with en_par low");
        step(1'b1, 1'b1, 1'b0, 4'd0, "R7 tc gated by en_casc");
        // R2: preset overrides counting.
        step(1'b0, 1'b1, 1'b1, 4'd5, "R2 preset beats count");
        // R3 R2: clear mid-cycle while a preset is requested.
        load_n = 1'b0; din = 4'd7; en_par = 1'b1; en_casc = 1'b1;
        rst_n = 1'b0; #1;
        check("R3 async clear", cnt_q, carry_out, 4'd0, 1'b0);
        model = 4'd0;
        step(1'b0, 1'b1, 1'b1, 4'd7, "R2 clear beats preset");
        rst_n = 1'b1; #1;
        check("R9 release again", cnt_q, carry_out, 4'd0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 4'd0, "R9 stays zero");
        // Random mode sequence.
        for (int k = 0; k < 300; k++) begin
            logic [6:0] r;
            r = 7'($urandom);
            step(r[0] | r[1], r[2] | r[6], r[3] | r[6], r[6:3], "R1 R4 R5 R6 R7 random");
        end
        @(negedge clk); @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule